// File: doc/BRIEF.md
# TFT Display Timing Generator

This block produces the raster timing for a TFT panel. A programmable divider derives a pixel clock from the system clock. Two phase sequencers step through sync, back porch, active and front porch. The horizontal sequencer advances once per pixel clock. The vertical sequencer advances once per completed line. From the two phase positions the block forms horizontal sync, vertical sync, data enable, an optional line-end strobe and a pixel-request strobe. The pixel data path passes through the block so that its polarity can be controlled with the other outputs.

All lengths are static configuration inputs, each encoded as the wanted count minus one. The current horizontal and vertical phases are presented as 2-bit status codes, and a line counter reports how many lines have elapsed in the current vertical phase. The enable input starts and stops the whole raster. While it is low, everything is held at the start of vertical sync and every output sits at its inactive level.

Top module: `tft_timing_gen`

## Requirements
- R1: The pixel clock period is 2*(div_i+1) system clocks. After `en_i` is first seen high, the first rising edge of the pixel clock occurs on the (div_i+1)-th system clock edge. When `clk_edge_i`=1, `pclk_o` is inverted so that data is qualified on the falling edge.
- R2: The horizontal sequence runs sync, back porch, active, front porch, lasting hsw_i+1, hbp_i+1, hact_i+1 and hfp_i+1 pixel clocks, and then repeats. `hstat_o` reports these phases as 0, 1, 2 and 3.
- R3: The vertical sequence advances by one line per complete horizontal sequence, in the order sync, back porch, active, front porch. These phases last vsw_i+1, vbp_i+1, vact_i+1 and vfp_i+1 lines, and `vstat_o` reports them as 0 to 3.
- R4: Data enable is active exactly while both phases are active (code 2). `de_o` equals that condition XOR `inv_de_i`.
- R5: `hsync_o` is (horizontal phase is sync) XOR `inv_hsync_i`. `vsync_o` is (vertical phase is sync) XOR `inv_vsync_i`.
- R6: With `lend_en_i`=1, the line-end strobe is active for one pixel clock: the first pixel of the horizontal front porch on lines whose vertical phase is active. With `lend_en_i`=0 it never asserts. `lend_o` is the strobe XOR `inv_lend_i`.
- R7: `pix_req_o` is high for one system clock, in the cycle before each pixel-clock rising edge, while data enable is active.
- R8: `pix_data_o` carries `pix_data_i` while data enable is active and zero otherwise. Every bit is XORed with `inv_data_i`.
- R9: `line_cnt_o` is the number of lines already completed within the current vertical phase, counting from 0.
- R10: While `en_i` is 0, both sequencers return to the first line and pixel of sync (status 0, line count 0) on the next clock edge. In that state `pclk_o` equals `clk_edge_i`, each polarity-controlled output equals its invert bit, and `pix_req_o` is 0. Re-enabling restarts the raster from that point.
- R11: After reset the block is in the same state as when it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Master video enable |
| div_i | input | 10 | Pixel clock divider value |
| hsw_i | input | 8 | Horizontal sync length minus one |
| hbp_i | input | 7 | Horizontal back porch length minus one |
| hact_i | input | 11 | Horizontal active length minus one |
| hfp_i | input | 8 | Horizontal front porch length minus one |
| vsw_i | input | 6 | Vertical sync length minus one (lines) |
| vbp_i | input | 8 | Vertical back porch length minus one |
| vact_i | input | 10 | Vertical active length minus one |
| vfp_i | input | 8 | Vertical front porch length minus one |
| inv_hsync_i | input | 1 | Invert horizontal sync |
| inv_vsync_i | input | 1 | Invert vertical sync |
| inv_de_i | input | 1 | Invert data enable |
| inv_data_i | input | 1 | Invert pixel data |
| inv_lend_i | input | 1 | Invert line-end strobe |
| clk_edge_i | input | 1 | Qualify data on the falling pixel-clock edge |
| lend_en_i | input | 1 | Enable the line-end strobe |
| pix_data_i | input | 24 | Pixel data in |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_data_o | output | 24 | Pixel data out |
| lend_o | output | 1 | Line-end strobe |
| pix_req_o | output | 1 | Pixel request strobe |
| hstat_o | output | 2 | Horizontal phase code |
| vstat_o | output | 2 | Vertical phase code |
| line_cnt_o | output | 10 | Lines elapsed in current vertical phase |

## Verification
The bench keeps the default field widths and programs a tiny raster: a 9-pixel line and a 7-line frame, with every phase one or a few units long. Several full frames are then swept cycle by cycle in a few hundred clocks. It runs this raster with divider values 0, 1 and 2, toggling every polarity bit, the edge select and the line-end enable between runs. Phase boundaries, frame wrap and the divider's first-tick offset all fall inside each sweep. A mid-frame disable and restart is also covered.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    function automatic int max_of2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tft_pix_div.sv
module tft_pix_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             pclk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pclk;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = en_i && (st_q.cnt == div_i) && !st_q.pclk;
        if (!en_i) begin
            st_d = '0;
        end else if (st_q.cnt == div_i) begin
            st_d.cnt  = '0;
            st_d.pclk = !st_q.pclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pclk_o = st_q.pclk;

    // R1: a tick is the edge on which the pixel clock rises
    a_r1_tick_rises: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> st_q.pclk);

    // R10: disabling parks the divider
    a_r10_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!st_q.pclk && st_q.cnt == '0));

endmodule

// File: rtl/tft_phase_seq.sv
module tft_phase_seq
    import tft_timing_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] len_sync_i,
    input  logic [CNT_W-1:0] len_back_i,
    input  logic [CNT_W-1:0] len_act_i,
    input  logic [CNT_W-1:0] len_front_i,
    output phase_t           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] len_sel;
    logic             at_end;

    always_comb begin
        unique case (st_q.phase)
            PH_SYNC:  len_sel = len_sync_i;
            PH_BACK:  len_sel = len_back_i;
            PH_ACT:   len_sel = len_act_i;
            default:  len_sel = len_front_i;
        endcase
        at_end = (st_q.cnt == len_sel);
        wrap_o = adv_i && at_end && (st_q.phase == PH_FRONT);

        st_d = st_q;
        if (clr_i) begin
            st_d.phase = PH_SYNC;
            st_d.cnt   = '0;
        end else if (adv_i) begin
            if (at_end) begin
                st_d.phase = phase_t'(st_q.phase + 2'd1);
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_SYNC;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign cnt_o   = st_q.cnt;

    // R2 / R3: phases only ever step forward by one code
    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ($stable(st_q.phase) ||
                    (st_q.phase == phase_t'($past(st_q.phase) + 2'd1))));

    // R2 / R3: inside one phase the count moves by one per advance
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> ((st_q.phase != $past(st_q.phase)) ||
                               (st_q.cnt == $past(st_q.cnt) + 1'b1)));

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
    import tft_timing_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int HSW_W  = 8,
    parameter int HBP_W  = 7,
    parameter int HACT_W = 11,
    parameter int HFP_W  = 8,
    parameter int VSW_W  = 6,
    parameter int VBP_W  = 8,
    parameter int VACT_W = 10,
    parameter int VFP_W  = 8,
    parameter int DW     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [HSW_W-1:0]  hsw_i,
    input  logic [HBP_W-1:0]  hbp_i,
    input  logic [HACT_W-1:0] hact_i,
    input  logic [HFP_W-1:0]  hfp_i,
    input  logic [VSW_W-1:0]  vsw_i,
    input  logic [VBP_W-1:0]  vbp_i,
    input  logic [VACT_W-1:0] vact_i,
    input  logic [VFP_W-1:0]  vfp_i,
    input  logic              inv_hsync_i,
    input  logic              inv_vsync_i,
    input  logic              inv_de_i,
    input  logic              inv_data_i,
    input  logic              inv_lend_i,
    input  logic              clk_edge_i,
    input  logic              lend_en_i,
    input  logic [DW-1:0]     pix_data_i,
    output logic              pclk_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [DW-1:0]     pix_data_o,
    output logic              lend_o,
    output logic              pix_req_o,
    output logic [1:0]        hstat_o,
    output logic [1:0]        vstat_o,
    output logic [VACT_W-1:0] line_cnt_o
);
    localparam int HCW = max_of2(max_of2(HSW_W, HBP_W), max_of2(HACT_W, HFP_W));
    localparam int VCW = max_of2(max_of2(VSW_W, VBP_W), max_of2(VACT_W, VFP_W));

    logic           tick, pclk_raw;
    phase_t         hph, vph;
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    logic           hwrap, vwrap_unused;
    logic           de_raw, lend_raw;

    tft_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .div_i  (div_i),
        .tick_o (tick),
        .pclk_o (pclk_raw)
    );

    tft_phase_seq #(.CNT_W(HCW)) u_hseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (!en_i),
        .adv_i       (tick),
        .len_sync_i  (HCW'(hsw_i)),
        .len_back_i  (HCW'(hbp_i)),
        .len_act_i   (HCW'(hact_i)),
        .len_front_i (HCW'(hfp_i)),
        .phase_o     (hph),
        .cnt_o       (hcnt),
        .wrap_o      (hwrap)
    );

    tft_phase_seq #(.CNT_W(VCW)) u_vseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (!en_i),
        .adv_i       (hwrap),
        .len_sync_i  (VCW'(vsw_i)),
        .len_back_i  (VCW'(vbp_i)),
        .len_act_i   (VCW'(vact_i)),
        .len_front_i (VCW'(vfp_i)),
        .phase_o     (vph),
        .cnt_o       (vcnt),
        .wrap_o      (vwrap_unused)
    );

    always_comb begin
        de_raw   = en_i && (hph == PH_ACT) && (vph == PH_ACT);
        lend_raw = en_i && lend_en_i && (hph == PH_FRONT) && (hcnt == '0)
                   && (vph == PH_ACT);

        pclk_o     = pclk_raw ^ clk_edge_i;
        hsync_o    = (en_i && hph == PH_SYNC) ^ inv_hsync_i;
        vsync_o    = (en_i && vph == PH_SYNC) ^ inv_vsync_i;
        de_o       = de_raw ^ inv_de_i;
        lend_o     = lend_raw ^ inv_lend_i;
        pix_req_o  = tick && de_raw;
        pix_data_o = (de_raw ? pix_data_i : '0) ^ {DW{inv_data_i}};
        hstat_o    = hph;
        vstat_o    = vph;
        line_cnt_o = VACT_W'(vcnt);
    end

    // R10: a disable parks both sequencers at the start of sync
    a_r10_off_park: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (hph == PH_SYNC && vph == PH_SYNC && hcnt == '0 && vcnt == '0));

    // R3: the vertical phase only moves when a line completes or on disable
    a_r3_v_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vph) |-> ($past(hwrap) || $past(!en_i)));

    // R6: a line-end strobe starts right after an active pixel
    a_r6_lend_after_de: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lend_raw) |-> $past(de_raw));

    // R7: a pixel request leads straight into a pixel clock rising edge
    a_r7_req_then_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req_o |=> pclk_raw);

endmodule

// File: tb/tft_timing_gen_tb_top.sv
module tft_timing_gen_tb_top;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = !clk;

    logic          en;
    logic [9:0]    div;
    logic [7:0]    hsw, hfp, vbp, vfp;
    logic [6:0]    hbp;
    logic [10:0]   hact;
    logic [5:0]    vsw;
    logic [9:0]    vact;
    logic          inv_h, inv_v, inv_de, inv_d, inv_l, edge_sel, lend_en;
    logic [DW-1:0] pdata;

    logic          pclk, hsync, vsync, de, lend, preq;
    logic [DW-1:0] pdo;
    logic [1:0]    hstat, vstat;
    logic [9:0]    lcnt;

    tft_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .div_i(div),
        .hsw_i(hsw), .hbp_i(hbp), .hact_i(hact), .hfp_i(hfp),
        .vsw_i(vsw), .vbp_i(vbp), .vact_i(vact), .vfp_i(vfp),
        .inv_hsync_i(inv_h), .inv_vsync_i(inv_v), .inv_de_i(inv_de),
        .inv_data_i(inv_d), .inv_lend_i(inv_l), .clk_edge_i(edge_sel),
        .lend_en_i(lend_en), .pix_data_i(pdata),
        .pclk_o(pclk), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
        .pix_data_o(pdo), .lend_o(lend), .pix_req_o(preq),
        .hstat_o(hstat), .vstat_o(vstat), .line_cnt_o(lcnt)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int phase_of(int pos, int l0, int l1, int l2);
        if (pos < l0) return 0;
        if (pos < l0 + l1) return 1;
        if (pos < l0 + l1 + l2) return 2;
        return 3;
    endfunction

    function automatic int phase_start(int ph, int l0, int l1, int l2);
        case (ph)
            0: return 0;
            1: return l0;
            2: return l0 + l1;
            default: return l0 + l1 + l2;
        endcase
    endfunction

    task automatic check_idle(input string req);
        chk(req, "pclk", int'(pclk), int'(edge_sel));
        chk(req, "hsync", int'(hsync), int'(inv_h));
        chk(req, "vsync", int'(vsync), int'(inv_v));
        chk(req, "de", int'(de), int'(inv_de));
        chk(req, "lend", int'(lend), int'(inv_l));
        chk(req, "preq", int'(preq), 0);
        chk(req, "pdata", int'(pdo), inv_d ? int'({DW{1'b1}}) : 0);
        chk(req, "hstat", int'(hstat), 0);
        chk(req, "vstat", int'(vstat), 0);
        chk(req, "line", int'(lcnt), 0);
    endtask

    // Enables at a negedge, then checks every system cycle for ncyc cycles.
    task automatic sweep(input int ncyc);
        int d1, h0, h1, h2, h3, ht, v0, v1, v2, v3, vt;
        d1 = int'(div) + 1;
        h0 = int'(hsw) + 1; h1 = int'(hbp) + 1; h2 = int'(hact) + 1; h3 = int'(hfp) + 1;
        v0 = int'(vsw) + 1; v1 = int'(vbp) + 1; v2 = int'(vact) + 1; v3 = int'(vfp) + 1;
        ht = h0 + h1 + h2 + h3;
        vt = v0 + v1 + v2 + v3;
        en = 1'b1;
        for (int c = 1; c <= ncyc; c++) begin
            int n, x, lf, hp, vp, de_e, lend_e, nxt_tick;
            @(posedge clk);
            @(negedge clk);
            pdata = DW'(c * 37 + 5);
            #1;
            n  = (c >= d1) ? ((c - d1) / (2 * d1) + 1) : 0;
            x  = n % ht;
            lf = (n / ht) % vt;
            hp = phase_of(x, h0, h1, h2);
            vp = phase_of(lf, v0, v1, v2);
            de_e = (hp == 2 && vp == 2) ? 1 : 0;
            lend_e = (lend_en && vp == 2 && x == h0 + h1 + h2) ? 1 : 0;
            nxt_tick = ((c + 1) >= d1 && ((c + 1 - d1) % (2 * d1)) == 0) ? 1 : 0;
            chk("R1", "pclk", int'(pclk), ((c / d1) % 2) ^ int'(edge_sel));
            chk("R2", "hstat", int'(hstat), hp);
            chk("R3", "vstat", int'(vstat), vp);
            chk("R4", "de", int'(de), de_e ^ int'(inv_de));
            chk("R5", "hsync", int'(hsync), (hp == 0 ? 1 : 0) ^ int'(inv_h));
            chk("R5", "vsync", int'(vsync), (vp == 0 ? 1 : 0) ^ int'(inv_v));
            chk("R6", "lend", int'(lend), lend_e ^ int'(inv_l));
            chk("R7", "preq", int'(preq), nxt_tick & de_e);
            chk("R8", "pdata", int'(pdo),
                int'((de_e != 0 ? pdata : '0) ^ {DW{inv_d}}));
            chk("R9", "line", int'(lcnt), lf - phase_start(vp, v0, v1, v2));
        end
    endtask

    task automatic disable_now();
        @(negedge clk);
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        check_idle("R10");
    endtask

    initial begin
        en = 0; div = 0;
        hsw = 8'd1; hbp = 7'd0; hact = 11'd3; hfp = 8'd1;
        vsw = 6'd0; vbp = 8'd1; vact = 10'd2; vfp = 8'd0;
        inv_h = 0; inv_v = 0; inv_de = 0; inv_d = 0; inv_l = 0;
        edge_sel = 0; lend_en = 1; pdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check_idle("R11");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle("R11");

        // Run A: divide by 2, plain polarity, line-end on
        sweep(300);
        disable_now();

        // Run B: divider 1, every polarity inverted, falling edge, line-end off
        div = 10'd1;
        inv_h = 1; inv_v = 1; inv_de = 1; inv_d = 1; inv_l = 1;
        edge_sel = 1; lend_en = 0;
        @(negedge clk);
        #1;
        check_idle("R10");
        sweep(560);
        disable_now();

        // Run C: divider 2, mixed polarity; stop mid-frame and restart
        div = 10'd2;
        inv_h = 0; inv_v = 1; inv_de = 0; inv_d = 1; inv_l = 0;
        edge_sel = 0; lend_en = 1;
        sweep(200);
        disable_now();
        sweep(820);
        disable_now();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule